// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

The block gathers fourteen interrupt sources and presents the CPU with a single pending interrupt and its 16-bit vector address. The sources are a power-on reset request, a software break, four pin inputs and eight internal event pulses. Twelve of them are maskable. Each maskable source has a request bit and an enable bit, and a global disable flag gates them all. Reset and break ignore every mask.

Nine vector slots are ranked by priority. Four slots are each shared by two maskable sources, and a 4-bit select register decides which of the two may use the slot. The CPU asserts an acknowledge while a request is presented. That clears the accepted request and sets the disable flag, so handlers do not nest unless software clears the flag again. Three of the pin inputs have a programmable active edge. The fourth, the key input, is always active on its falling edge. Every pin passes through a two-flop synchroniser before edge detection.

Top module: `irq_vec_ctrl`

## Requirements
- R1: Reset state: disable flag 1, all requests 0, all enables 0, select 0, polarity 0. A reset request is pending, so `irq_o`=1 and `vec_o`=16'hFFFC. One acknowledge clears it, and it does not return until the next reset.
- R2: A source's event sets its request bit whatever the enable, select and disable flag. The bit holds until acceptance or a software clear. `req_o` bits: 0 rx, 1 ev1, 2 tx, 3 int1 pin, 4 int0 pin, 5 tmx, 6 key pin, 7 tm1, 8 tm2, 9 sio, 10 cntr pin, 11 adc. `int_evt_i` bits 0..7 drive sources 0,1,2,5,7,8,9,11.
- R3: Slot n (0..8) presents vector 16'hFFFC-2n. Slot 0 is reset. Slots 1 to 8 hold, in order: rx; ev1; tx/int1; int0; tmx/key; tm1; tm2/sio; cntr/adc, with break also on slot 8. `irq_o` is 1 whenever some slot is eligible.
- R4: `ack_i` while `irq_o`=1 clears the accepted request and sets the disable flag on that edge, overriding a same-cycle flag write. `ack_i` while `irq_o`=0 changes nothing.
- R5: When several slots are eligible, the lowest slot number wins.
- R6: Select bit k picks the second source of its shared slot when 1: bit 0 for slot 3, bit 1 for slot 5, bit 2 for slot 7, bit 3 for slot 8. An unselected source keeps its request but cannot interrupt.
- R7: Reset and break are eligible regardless of enables and the disable flag. On slot 8 a pending break is accepted before the maskable source.
- R8: `ext_i` bits are 0 int0, 1 int1, 2 cntr, 3 key. For bits 0..2, `pol_i` bit 1 selects the rising edge and 0 the falling edge. Key is always falling-edge. A pin change driven before clock edge k shows in `req_o` after edge k+2.
- R9: Writing a polarity that makes the current synchronised pin level active sets that source's request one edge after the write.
- R10: An event on the same edge as a software clear or an acknowledge of the same bit leaves the bit set. A break pulse on the edge that accepts a break leaves break pending.
- R11: A software clear clears only the masked bits and never sets a bit. Enable and disable-flag writes take effect on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| int_evt_i | input | 8 | Internal event pulses |
| ext_i | input | 4 | Asynchronous pin inputs |
| brk_i | input | 1 | Software break pulse |
| ack_i | input | 1 | CPU acceptance of the presented interrupt |
| en_wr_i | input | 1 | Enable register write strobe |
| en_i | input | 12 | Enable write data |
| req_clr_i | input | 1 | Request clear strobe |
| req_clr_mask_i | input | 12 | Request bits to clear |
| sel_wr_i | input | 1 | Shared-slot select write strobe |
| sel_i | input | 4 | Shared-slot select data |
| pol_wr_i | input | 1 | Edge polarity write strobe |
| pol_i | input | 3 | Edge polarity data (1 = rising) |
| iflag_wr_i | input | 1 | Disable flag write strobe |
| iflag_i | input | 1 | Disable flag write data |
| irq_o | output | 1 | An interrupt is presented |
| vec_o | output | 16 | Low address of the presented vector pair |
| iflag_o | output | 1 | Global disable flag |
| req_o | output | 12 | Request bits |

## Verification
The bench presses on the unselected half of a shared slot. A design that ignored the select bit would fire on a source software did not choose. It fires a break and an A-D request together to check that break goes first and that the A-D request survives. Getting this wrong would lose one of the two or take them in the wrong order. It flips a polarity while a pin is static and expects a request. A detector that compared only raw pin history would miss this. It also lands events on the same edge as a clear or an acknowledge, where a clear-priority design would silently drop an interrupt.

// File: rtl/irq_vec_pkg.sv
`timescale 1ns/1ps
package irq_vec_pkg;
  localparam int NUM_SRC  = 12;
  localparam int NUM_INT  = 8;
  localparam int NUM_EXT  = 4;
  localparam int NUM_POL  = 3;
  localparam int NUM_SHR  = 4;
  localparam int NUM_SLOT = 9;
  localparam int VEC_W    = 16;
  localparam int SLOT_W   = $clog2(NUM_SLOT);
  localparam int BRK_SLOT = NUM_SLOT - 1;
  localparam logic [VEC_W-1:0] VEC_TOP = 16'hFFFC;

  localparam int S_RX   = 0;
  localparam int S_EV1  = 1;
  localparam int S_TX   = 2;
  localparam int S_INT1 = 3;
  localparam int S_INT0 = 4;
  localparam int S_TMX  = 5;
  localparam int S_KEY  = 6;
  localparam int S_TM1  = 7;
  localparam int S_TM2  = 8;
  localparam int S_SIO  = 9;
  localparam int S_CNTR = 10;
  localparam int S_ADC  = 11;

  // first source of a slot
  function automatic int slot_pri(int s);
    case (s)
      1: return S_RX;
      2: return S_EV1;
      3: return S_TX;
      4: return S_INT0;
      5: return S_TMX;
      6: return S_TM1;
      7: return S_TM2;
      8: return S_CNTR;
      default: return 0;
    endcase
  endfunction

  // second source of a shared slot, equal to the first otherwise
  function automatic int slot_alt(int s);
    case (s)
      3: return S_INT1;
      5: return S_KEY;
      7: return S_SIO;
      8: return S_ADC;
      default: return slot_pri(s);
    endcase
  endfunction

  // select bit used by a slot, -1 when not shared
  function automatic int slot_sel(int s);
    case (s)
      3: return 0;
      5: return 1;
      7: return 2;
      8: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic int int_src(int k);
    case (k)
      0: return S_RX;
      1: return S_EV1;
      2: return S_TX;
      3: return S_TMX;
      4: return S_TM1;
      5: return S_TM2;
      6: return S_SIO;
      default: return S_ADC;
    endcase
  endfunction

  function automatic int ext_src(int k);
    case (k)
      0: return S_INT0;
      1: return S_INT1;
      2: return S_CNTR;
      default: return S_KEY;
    endcase
  endfunction
endpackage

// File: rtl/irq_edge_det.sv
`timescale 1ns/1ps
module irq_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic rise_i,
  output logic evt_o
);
  logic s1_q, s2_q, lvl_prev_q, lvl;

  // active level normalised to 1; a polarity flip can itself make an edge
  assign lvl   = rise_i ? s2_q : ~s2_q;
  assign evt_o = lvl & ~lvl_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q       <= 1'b0;
      s2_q       <= 1'b0;
      lvl_prev_q <= 1'b1;
    end else begin
      s1_q       <= pin_i;
      s2_q       <= s1_q;
      lvl_prev_q <= lvl;
    end
  end
endmodule

// File: rtl/irq_req_bank.sv
`timescale 1ns/1ps
module irq_req_bank import irq_vec_pkg::*; (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  input  logic               en_wr_i,
  input  logic [NUM_SRC-1:0] en_i,
  output logic [NUM_SRC-1:0] req_o,
  output logic [NUM_SRC-1:0] en_o
);
  logic [NUM_SRC-1:0] req_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= '0;
      en_q  <= '0;
    end else begin
      req_q <= (req_q & ~clr_i) | set_i;  // set wins
      if (en_wr_i) en_q <= en_i;
    end
  end

  assign req_o = req_q;
  assign en_o  = en_q;
endmodule

// File: rtl/irq_prio_sel.sv
`timescale 1ns/1ps
module irq_prio_sel import irq_vec_pkg::*; (
  input  logic               rst_pend_i,
  input  logic               brk_pend_i,
  input  logic               iflag_i,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic [NUM_SHR-1:0] sel_i,
  output logic               hit_o,
  output logic [SLOT_W-1:0]  slot_o,
  output logic               brk_take_o,
  output logic [NUM_SRC-1:0] src_clr_o
);
  logic [NUM_SLOT-1:0] elig;
  logic [NUM_SRC-1:0]  clr_oh [NUM_SLOT];

  assign elig[0]   = rst_pend_i;
  assign clr_oh[0] = '0;

  for (genvar s = 1; s < NUM_SLOT; s++) begin : g_slot
    localparam int P  = slot_pri(s);
    localparam int A  = slot_alt(s);
    localparam int SB = slot_sel(s);
    logic take_alt, mask_ok, nmi;
    if (SB >= 0) begin : g_shr
      assign take_alt = sel_i[SB];
    end else begin : g_dir
      assign take_alt = 1'b0;
    end
    if (s == BRK_SLOT) begin : g_brk
      assign nmi = brk_pend_i;
    end else begin : g_nobrk
      assign nmi = 1'b0;
    end
    assign mask_ok   = ~iflag_i & (take_alt ? (req_i[A] & en_i[A]) : (req_i[P] & en_i[P]));
    assign elig[s]   = mask_ok | nmi;
    assign clr_oh[s] = take_alt ? (NUM_SRC'(1) << A) : (NUM_SRC'(1) << P);
  end

  always_comb begin
    hit_o  = 1'b0;
    slot_o = '0;
    for (int s = NUM_SLOT - 1; s >= 0; s--) begin
      if (elig[s]) begin
        hit_o  = 1'b1;
        slot_o = SLOT_W'(s);
      end
    end
  end

  always_comb begin
    brk_take_o = hit_o && (slot_o == SLOT_W'(BRK_SLOT)) && brk_pend_i;
    src_clr_o  = (hit_o && !brk_take_o) ? clr_oh[slot_o] : '0;
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
`timescale 1ns/1ps
module irq_vec_ctrl import irq_vec_pkg::*; (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_INT-1:0] int_evt_i,
  input  logic [NUM_EXT-1:0] ext_i,
  input  logic               brk_i,
  input  logic               ack_i,
  input  logic               en_wr_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic               req_clr_i,
  input  logic [NUM_SRC-1:0] req_clr_mask_i,
  input  logic               sel_wr_i,
  input  logic [NUM_SHR-1:0] sel_i,
  input  logic               pol_wr_i,
  input  logic [NUM_POL-1:0] pol_i,
  input  logic               iflag_wr_i,
  input  logic               iflag_i,
  output logic               irq_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic               iflag_o,
  output logic [NUM_SRC-1:0] req_o
);
  logic               rst_pend_q, brk_q, iflag_q;
  logic [NUM_SHR-1:0] sel_q;
  logic [NUM_POL-1:0] pol_q;
  logic [NUM_EXT-1:0] ext_evt;
  logic [NUM_SRC-1:0] src_set, src_clr, ack_clr, en_q, req_q;
  logic               hit, brk_take, take;
  logic [SLOT_W-1:0]  slot;

  for (genvar c = 0; c < NUM_EXT; c++) begin : g_ext
    logic rise;
    if (c < NUM_POL) begin : g_prog
      assign rise = pol_q[c];
    end else begin : g_fall
      assign rise = 1'b0;
    end
    irq_edge_det u_det (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pin_i (ext_i[c]),
      .rise_i(rise),
      .evt_o (ext_evt[c])
    );
  end

  always_comb begin
    src_set = '0;
    for (int k = 0; k < NUM_INT; k++) src_set[int_src(k)] = int_evt_i[k];
    for (int k = 0; k < NUM_EXT; k++) src_set[ext_src(k)] = ext_evt[k];
  end

  assign take    = ack_i & hit;
  assign src_clr = (req_clr_i ? req_clr_mask_i : '0) | (take ? ack_clr : '0);

  irq_req_bank u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (src_set),
    .clr_i  (src_clr),
    .en_wr_i(en_wr_i),
    .en_i   (en_i),
    .req_o  (req_q),
    .en_o   (en_q)
  );

  irq_prio_sel u_prio (
    .rst_pend_i(rst_pend_q),
    .brk_pend_i(brk_q),
    .iflag_i   (iflag_q),
    .req_i     (req_q),
    .en_i      (en_q),
    .sel_i     (sel_q),
    .hit_o     (hit),
    .slot_o    (slot),
    .brk_take_o(brk_take),
    .src_clr_o (ack_clr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_pend_q <= 1'b1;
      brk_q      <= 1'b0;
      iflag_q    <= 1'b1;
      sel_q      <= '0;
      pol_q      <= '0;
    end else begin
      if (take && slot == '0) rst_pend_q <= 1'b0;
      brk_q <= brk_i | (brk_q & ~(take & brk_take));
      if (take)            iflag_q <= 1'b1;
      else if (iflag_wr_i) iflag_q <= iflag_i;
      if (sel_wr_i) sel_q <= sel_i;
      if (pol_wr_i) pol_q <= pol_i;
    end
  end

  assign irq_o   = hit;
  assign vec_o   = VEC_TOP - (VEC_W'(slot) << 1);
  assign iflag_o = iflag_q;
  assign req_o   = req_q;
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
`timescale 1ns/1ps
module irq_vec_ctrl_chk import irq_vec_pkg::*; (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ack_i,
  input logic               req_clr_i,
  input logic [NUM_SRC-1:0] src_set,
  input logic               irq_o,
  input logic [VEC_W-1:0]   vec_o,
  input logic               iflag_o,
  input logic [NUM_SRC-1:0] req_o
);
  localparam logic [VEC_W-1:0] VEC_BOT = VEC_TOP - VEC_W'(2 * (NUM_SLOT - 1));

  // R4
  ack_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && irq_o |=> iflag_o);

  // R7
  masked_only_nmi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iflag_o && irq_o |-> (vec_o == VEC_TOP || vec_o == VEC_BOT));

  // R3
  vec_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (vec_o[0] == 1'b0 && vec_o <= VEC_TOP && vec_o >= VEC_BOT));

  // R1
  rst_vec_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && irq_o && vec_o == VEC_TOP |=> !(irq_o && vec_o == VEC_TOP));

  // R2
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_set == '0 && !req_clr_i && !ack_i) |=> $stable(req_o));

  // R10
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_set != '0) |=> ((req_o & $past(src_set)) == $past(src_set)));
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ack_i    (ack_i),
  .req_clr_i(req_clr_i),
  .src_set  (src_set),
  .irq_o    (irq_o),
  .vec_o    (vec_o),
  .iflag_o  (iflag_o),
  .req_o    (req_o)
);

// File: tb/tb_irq_vec_ctrl.sv
`timescale 1ns/1ps
module tb_irq_vec_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  int_evt = '0;
  logic [3:0]  ext = '0;
  logic        brk = 1'b0, ack = 1'b0;
  logic        en_wr = 1'b0, req_clr = 1'b0, sel_wr = 1'b0, pol_wr = 1'b0, iflag_wr = 1'b0;
  logic [11:0] en_d = '0, clr_mask = '0;
  logic [3:0]  sel_d = '0;
  logic [2:0]  pol_d = '0;
  logic        iflag_d = 1'b0;
  logic        irq_o, iflag_o;
  logic [15:0] vec_o;
  logic [11:0] req_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_vec_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .int_evt_i(int_evt), .ext_i(ext),
    .brk_i(brk), .ack_i(ack), .en_wr_i(en_wr), .en_i(en_d),
    .req_clr_i(req_clr), .req_clr_mask_i(clr_mask), .sel_wr_i(sel_wr), .sel_i(sel_d),
    .pol_wr_i(pol_wr), .pol_i(pol_d), .iflag_wr_i(iflag_wr), .iflag_i(iflag_d),
    .irq_o(irq_o), .vec_o(vec_o), .iflag_o(iflag_o), .req_o(req_o)
  );

  // behavioural reference
  bit        m_rst, m_brk, m_iflag;
  bit [11:0] m_req, m_en;
  bit [3:0]  m_sel, d1, d2, prev;
  bit [2:0]  m_pol;

  function automatic int m_src(int slot);
    case (slot)
      1: return 0;
      2: return 1;
      3: return m_sel[0] ? 3 : 2;
      4: return 4;
      5: return m_sel[1] ? 6 : 5;
      6: return 7;
      7: return m_sel[2] ? 9 : 8;
      default: return m_sel[3] ? 11 : 10;
    endcase
  endfunction

  function automatic int m_win();
    if (m_rst) return 0;
    for (int s = 1; s <= 8; s++) begin
      int src = m_src(s);
      if ((!m_iflag && m_req[src] && m_en[src]) || (s == 8 && m_brk)) return s;
    end
    return -1;
  endfunction

  function automatic int int_map(int k);
    case (k)
      0: return 0; 1: return 1; 2: return 2; 3: return 5;
      4: return 7; 5: return 8; 6: return 9; default: return 11;
    endcase
  endfunction

  function automatic int ext_map(int k);
    case (k)
      0: return 4; 1: return 3; 2: return 10; default: return 6;
    endcase
  endfunction

  always @(posedge clk) begin : model
    int w;
    bit lvl;
    bit [11:0] set, clr;
    if (!rst_n) begin
      m_rst = 1; m_brk = 0; m_iflag = 1; m_req = '0; m_en = '0;
      m_sel = '0; m_pol = '0; d1 = '0; d2 = '0; prev = 4'hF;
    end else begin
      w = m_win();
      set = '0;
      for (int ch = 0; ch < 4; ch++) begin
        lvl = (ch < 3 && m_pol[ch]) ? d2[ch] : !d2[ch];
        if (lvl && !prev[ch]) set[ext_map(ch)] = 1'b1;
        prev[ch] = lvl;
      end
      d2 = d1;
      d1 = ext;
      for (int k = 0; k < 8; k++) if (int_evt[k]) set[int_map(k)] = 1'b1;
      clr = req_clr ? clr_mask : '0;
      if (ack && w >= 0) begin
        m_iflag = 1;
        if (w == 0) m_rst = 0;
        else if (w == 8 && m_brk) m_brk = 0;
        else clr[m_src(w)] = 1'b1;
      end else if (iflag_wr) m_iflag = iflag_d;
      if (brk) m_brk = 1;
      m_req = (m_req & ~clr) | set;
      if (en_wr) m_en = en_d;
      if (sel_wr) m_sel = sel_d;
      if (pol_wr) m_pol = pol_d;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin : cmp
    int w;
    if (rst_n && !done) begin
      w = m_win();
      chk("R3 model irq", 32'(irq_o), 32'(w >= 0));
      if (w >= 0) chk("R3 model vec", 32'(vec_o), 32'(16'hFFFC - 16'(2 * w)));
      chk("R4 model iflag", 32'(iflag_o), 32'(m_iflag));
      chk("R2 model req", 32'(req_o), 32'(m_req));
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic do_ack();
    ack = 1; tick(1); ack = 0;
  endtask
  task automatic pulse_int(logic [7:0] v);
    int_evt = v; tick(1); int_evt = '0;
  endtask
  task automatic sw_clr(logic [11:0] m);
    req_clr = 1; clr_mask = m; tick(1); req_clr = 0; clr_mask = '0;
  endtask
  task automatic wr_en(logic [11:0] v);
    en_wr = 1; en_d = v; tick(1); en_wr = 0;
  endtask
  task automatic wr_sel(logic [3:0] v);
    sel_wr = 1; sel_d = v; tick(1); sel_wr = 0;
  endtask
  task automatic wr_pol(logic [2:0] v);
    pol_wr = 1; pol_d = v; tick(1); pol_wr = 0;
  endtask
  task automatic wr_iflag(logic v);
    iflag_wr = 1; iflag_d = v; tick(1); iflag_wr = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    // R1 reset state
    chk("R1 irq", 32'(irq_o), 1);
    chk("R1 vec", 32'(vec_o), 32'hFFFC);
    chk("R1 iflag", 32'(iflag_o), 1);
    chk("R1 req", 32'(req_o), 0);
    do_ack(); tick(1);
    chk("R1 reset request gone", 32'(irq_o), 0);

    // R2 request latched with enable off
    pulse_int(8'h01); tick(1);
    chk("R2 req without enable", 32'(req_o), 32'h001);
    chk("R2 no irq without enable", 32'(irq_o), 0);
    wr_en(12'hFFF); tick(1);
    chk("R4 flag masks", 32'(irq_o), 0);
    wr_iflag(1'b0); tick(1);
    chk("R3 slot1 vec", 32'(vec_o), 32'hFFFA);

    // R5 priority
    pulse_int(8'h90); tick(1);
    chk("R2 req set", 32'(req_o), 32'h881);
    chk("R5 lowest wins", 32'(vec_o), 32'hFFFA);
    sw_clr(12'h001); tick(1);
    chk("R5 next slot", 32'(vec_o), 32'hFFF0);
    sw_clr(12'h080); tick(1);
    chk("R6 unselected blocked", 32'(irq_o), 0);
    chk("R6 unselected kept", 32'(req_o), 32'h800);
    wr_sel(4'b1000); tick(1);
    chk("R6 selected fires", 32'(vec_o), 32'hFFEC);
    do_ack(); tick(1);
    chk("R4 ack sets flag", 32'(iflag_o), 1);
    chk("R4 ack clears req", 32'(req_o), 0);

    // R7 break bypasses flag
    brk = 1; tick(1); brk = 0; tick(1);
    chk("R7 break masked flag", 32'(vec_o), 32'hFFEC);
    do_ack(); tick(1);
    chk("R7 break cleared", 32'(irq_o), 0);
    brk = 1; int_evt = 8'h80; tick(1); brk = 0; int_evt = '0;
    wr_iflag(1'b0); tick(1);
    chk("R7 shared with adc", 32'(vec_o), 32'hFFEC);
    do_ack(); tick(1);
    chk("R7 break first adc kept", 32'(req_o), 32'h800);
    wr_iflag(1'b0); tick(1);
    chk("R7 adc then", 32'(vec_o), 32'hFFEC);
    do_ack(); tick(1);
    chk("R4 adc cleared", 32'(req_o), 0);
    wr_iflag(1'b0);

    // R8 int0 falling edge, latency
    ext[0] = 1; tick(5);
    chk("R8 rising ignored", 32'(req_o), 0);
    ext[0] = 0; tick(2);
    chk("R8 not yet", 32'(req_o), 0);
    tick(1);
    chk("R8 falling seen", 32'(req_o), 32'h010);
    chk("R8 slot4 vec", 32'(vec_o), 32'hFFF4);
    do_ack(); tick(1);
    wr_iflag(1'b0);

    // R9 polarity flip sets request
    ext[1] = 1; tick(5);
    chk("R8 int1 rising ignored", 32'(req_o), 0);
    wr_pol(3'b010); tick(1);
    chk("R9 flip sets req", 32'(req_o), 32'h008);
    chk("R6 int1 unselected", 32'(irq_o), 0);
    wr_sel(4'b1001); tick(1);
    chk("R6 int1 selected", 32'(vec_o), 32'hFFF6);
    sw_clr(12'h008); tick(1);
    chk("R11 cleared", 32'(req_o), 0);

    // R8 key fixed falling
    ext[3] = 1; tick(5);
    chk("R8 key rising ignored", 32'(req_o), 0);
    ext[3] = 0; tick(4);
    chk("R8 key falling", 32'(req_o), 32'h040);
    sw_clr(12'h040);
    // R8 cntr rising
    wr_pol(3'b110); tick(2);
    ext[2] = 1; tick(4);
    chk("R8 cntr rising", 32'(req_o), 32'h400);
    sw_clr(12'h400); tick(1);

    // R10 set beats clear and ack
    int_evt = 8'h01; req_clr = 1; clr_mask = 12'h001; tick(1);
    int_evt = '0; req_clr = 0; clr_mask = '0;
    chk("R10 set beats clear", 32'(req_o), 32'h001);
    chk("R10 irq", 32'(vec_o), 32'hFFFA);
    int_evt = 8'h01; ack = 1; tick(1); int_evt = '0; ack = 0;
    chk("R10 set beats ack", 32'(req_o), 32'h001);
    chk("R4 flag set", 32'(iflag_o), 1);

    // R11 clear never sets, enable writes
    sw_clr(12'h002); tick(1);
    chk("R11 clear no set", 32'(req_o), 32'h001);
    wr_en(12'h000); wr_iflag(1'b0); tick(1);
    chk("R11 enable off", 32'(irq_o), 0);
    do_ack(); tick(1);
    chk("R4 idle ack ignored", 32'(iflag_o), 0);
    wr_en(12'h001); tick(1);
    chk("R11 enable on", 32'(vec_o), 32'hFFFA);
    tick(3);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule